// File: doc/BRIEF.md
# Multiplexed DDR Lane Steering Decoder

This block decodes each access of a DDR controller whose narrow data bus reaches a wider external memory bank through external bus switches. From the access address, a programmable chip-select base and mask, a write flag and the byte enables, it decides three things:

- whether the chip select hits;
- which bus-switch output enables to assert;
- which data-mask bits carry the byte enables.

The external bank is split into byte-lane groups. Which group is active comes from the top offset bits inside the chip-select window. In 32-bit mode the window has two groups. In 16-bit mode it has four.

The decode is evaluated every cycle and all outputs are registered, so they appear one clock edge after the inputs. Every pin is a plain control or status pin. There is no streaming interface and no back-pressure: an access held on the inputs yields the same outputs on every following edge.

When multiplexing is enabled, software programs the mask for a window two times (32-bit mode) or four times (16-bit mode) the normal span. The window size is taken from the lowest set bit of the mask. A 1 GB window therefore gives 512 MB halves or 256 MB quarters.

Top module: `ddr_lane_steer`

## Requirements
- R1: The chip select hits when `((addr_i ^ cs_base_i) & cs_mask_i) == 0`. The registered `cs_hit_o` reflects the inputs applied before the previous rising edge.
- R2: On a miss, `oe_o` is 4'b0000 and `dm_o` is 8'hFF.
- R3: With `mux_en_i`=1 and `mode16_i`=0 (32-bit mode), a hit with region bit 0 gives `oe_o`=4'b0011, and region bit 1 gives `oe_o`=4'b1100.
- R4: In the mode of R3, a write to region 0 drives `dm_o[3:0]=~be_i`. A write to region 1 drives `dm_o[7:4]=~be_i`. All other mask bits are 1.
- R5: With `mux_en_i`=1 and `mode16_i`=1 (16-bit mode), a hit on quarter k (0 = lowest address) sets only `oe_o[k]`.
- R6: In the mode of R5, a write to quarter k drives `dm_o[2k+1:2k]=~be_i[1:0]`. All other mask bits are 1, and `be_i[3:2]` are ignored.
- R7: Let p be the position of the lowest set bit of `cs_mask_i` (p=32 when the mask is zero). The region index is `addr_i[p-1]` in 32-bit mode and `{addr_i[p-1],addr_i[p-2]}` in 16-bit mode. Any bit with a negative position reads as 0.
- R8: A read (`we_i`=0) that hits asserts the same output enables as a write would, with `dm_o`=8'hFF.
- R9: With `mux_en_i`=0, a hit gives `oe_o`=4'b0011. A write drives `dm_o[3:0]=~be_i` in 32-bit mode, or `dm_o[1:0]=~be_i[1:0]` in 16-bit mode, and sets every other mask bit.
- R10: A synchronous reset (`rst`=1 at a rising edge) clears `cs_hit_o` and `oe_o` and sets `dm_o` to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 32 | Access address |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables, active high |
| mode16_i | input | 1 | 1 = 16-bit bus mode, 0 = 32-bit |
| mux_en_i | input | 1 | Data bus multiplexing enable |
| cs_base_i | input | 32 | Chip-select base address |
| cs_mask_i | input | 32 | Chip-select mask, 1 = compared bit |
| cs_hit_o | output | 1 | Registered chip-select hit |
| oe_o | output | 4 | Registered bus-switch output enables |
| dm_o | output | 8 | Registered data mask, 1 = byte masked |

## Verification
The bench exercises the window-boundary addresses in several places:

- **Last byte below a half or quarter, and first byte above it.** Picking the region bit one position off moves the lane group by one and shows up as wrong `oe_o` and `dm_o`.
- **Very small masks and the all-zero mask.** These test the negative-position rule. An off-by-one in the lowest-set-bit search shows up as the wrong region.
- **Reads.** A design that leaks byte enables onto the mask during reads is caught.
- **16-bit writes with `be_i[3:2]` set.** A design that routes the unused enables is caught.
- **Multiplexing disabled, in both modes.** A design that still steers by region in this case is caught.
- **Random masks, bases and addresses.** These cover hits and misses across window sizes from 4 bytes to 2 GB.

// File: rtl/ddr_steer_pkg.sv
package ddr_steer_pkg;
  localparam int OE_W = 4;
  localparam int DM_W = 8;
  localparam int BE_W = 4;
  typedef enum logic {
    BUS32 = 1'b0,
    BUS16 = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/ddr_window_match.sv
module ddr_window_match #(
  parameter int ADDR_W = 32,
  parameter int POS_W  = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit,
  output logic [POS_W-1:0]  low_pos
);
  always_comb begin
    hit = ((addr ^ base) & mask) == '0;
  end

  // position of lowest set mask bit, ADDR_W when mask is zero
  always_comb begin
    low_pos = POS_W'(ADDR_W);
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      if (mask[i]) low_pos = POS_W'(i);
    end
  end
endmodule

// File: rtl/ddr_region_pick.sv
module ddr_region_pick #(
  parameter int ADDR_W = 32,
  parameter int POS_W  = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [POS_W-1:0]  low_pos,
  input  logic              is16,
  output logic [1:0]        region
);
  logic top_bit;
  logic next_bit;

  always_comb begin
    top_bit  = 1'b0;
    next_bit = 1'b0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i + 1 == int'(low_pos)) top_bit  = addr[i];
      if (i + 2 == int'(low_pos)) next_bit = addr[i];
    end
    region = is16 ? {top_bit, next_bit} : {1'b0, top_bit};
  end
endmodule

// File: rtl/ddr_lane_route.sv
module ddr_lane_route
  import ddr_steer_pkg::*;
(
  input  logic            hit,
  input  logic            we,
  input  logic            mux_en,
  input  bus_mode_e       mode,
  input  logic [1:0]      region,
  input  logic [BE_W-1:0] be,
  output logic [OE_W-1:0] oe,
  output logic [DM_W-1:0] dm
);
  localparam int HALF_W = DM_W / 2;
  localparam int QTR_W  = DM_W / 4;

  always_comb begin
    oe = '0;
    dm = '1;
    if (hit) begin
      if (!mux_en) begin
        oe = OE_W'(4'b0011);
        if (we) begin
          if (mode == BUS16) dm[QTR_W-1:0] = ~be[QTR_W-1:0];
          else               dm[HALF_W-1:0] = ~be;
        end
      end else if (mode == BUS32) begin
        oe = region[0] ? OE_W'(4'b1100) : OE_W'(4'b0011);
        if (we) begin
          for (int g = 0; g < 2; g++) begin
            if (region[0] == g[0]) dm[g*HALF_W +: HALF_W] = ~be;
          end
        end
      end else begin
        oe[region] = 1'b1;
        if (we) begin
          for (int q = 0; q < 4; q++) begin
            if (region == 2'(q)) dm[q*QTR_W +: QTR_W] = ~be[QTR_W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/ddr_lane_steer.sv
module ddr_lane_steer
  import ddr_steer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              mode16_i,
  input  logic              mux_en_i,
  input  logic [ADDR_W-1:0] cs_base_i,
  input  logic [ADDR_W-1:0] cs_mask_i,
  output logic              cs_hit_o,
  output logic [OE_W-1:0]   oe_o,
  output logic [DM_W-1:0]   dm_o
);
  localparam int POS_W = $clog2(ADDR_W + 1);

  logic             hit_c;
  logic [POS_W-1:0] low_pos;
  logic [1:0]       region;
  logic [OE_W-1:0]  oe_c;
  logic [DM_W-1:0]  dm_c;
  bus_mode_e        mode;

  assign mode = bus_mode_e'(mode16_i);

  ddr_window_match #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_match (
    .addr(addr_i), .base(cs_base_i), .mask(cs_mask_i),
    .hit(hit_c), .low_pos(low_pos)
  );

  ddr_region_pick #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_pick (
    .addr(addr_i), .low_pos(low_pos), .is16(mode16_i), .region(region)
  );

  ddr_lane_route u_route (
    .hit(hit_c), .we(we_i), .mux_en(mux_en_i), .mode(mode),
    .region(region), .be(be_i), .oe(oe_c), .dm(dm_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_hit_o <= 1'b0;
      oe_o     <= '0;
      dm_o     <= '1;
    end else begin
      cs_hit_o <= hit_c;
      oe_o     <= oe_c;
      dm_o     <= dm_c;
    end
  end

  // R10
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!cs_hit_o && oe_o == '0 && dm_o == '1));

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_hit_o |-> (oe_o == '0 && dm_o == '1));

  // R8
  read_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!we_i) |-> dm_o == '1);

  // R5
  quarter_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_hit_o && $past(mux_en_i && mode16_i)) |-> $countones(oe_o) == 1);

  // R3
  half_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_hit_o && $past(mux_en_i && !mode16_i)) |->
      (oe_o == 4'b0011 || oe_o == 4'b1100));

  // R9
  plain_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_hit_o && $past(!mux_en_i)) |-> oe_o == 4'b0011);

  // R4
  lane_width_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~dm_o) <= BE_W);
endmodule

// File: tb/sim_ddr_lane_steer.sv
module sim_ddr_lane_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [3:0]  be_i = '0;
  logic        mode16_i = 1'b0;
  logic        mux_en_i = 1'b0;
  logic [31:0] cs_base_i = '0;
  logic [31:0] cs_mask_i = '0;
  logic        cs_hit_o;
  logic [3:0]  oe_o;
  logic [7:0]  dm_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddr_lane_steer u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .we_i(we_i), .be_i(be_i),
    .mode16_i(mode16_i), .mux_en_i(mux_en_i), .cs_base_i(cs_base_i),
    .cs_mask_i(cs_mask_i), .cs_hit_o(cs_hit_o), .oe_o(oe_o), .dm_o(dm_o)
  );

  // expected {hit, oe[3:0], dm[7:0]}
  function automatic logic [12:0] model(input logic [31:0] a, input logic w,
      input logic [3:0] be, input logic m16, input logic mx,
      input logic [31:0] b, input logic [31:0] m);
    logic hit; logic [3:0] oe; logic [7:0] dm; int p; int k;
    hit = ((a ^ b) & m) == 0;
    oe = 4'h0; dm = 8'hFF;
    p = 32;
    for (int i = 31; i >= 0; i--) if (m[i]) p = i;
    k = 0;
    if (p >= 1 && a[p-1]) k = m16 ? 2 : 1;
    if (m16 && p >= 2 && a[p-2]) k = k + 1;
    if (hit) begin
      if (!mx) begin
        oe = 4'b0011;
        if (w) begin
          if (m16) dm[1:0] = ~be[1:0];
          else     dm[3:0] = ~be;
        end
      end else if (!m16) begin
        oe = (k == 1) ? 4'b1100 : 4'b0011;
        if (w) dm[k*4 +: 4] = ~be;
      end else begin
        oe[k] = 1'b1;
        if (w) dm[k*2 +: 2] = ~be[1:0];
      end
    end
    return {hit, oe, dm};
  endfunction

  task automatic check(input string req, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got hit=%b oe=%b dm=%h, expected hit=%b oe=%b dm=%h",
               req, got[12], got[11:8], got[7:0], exp[12], exp[11:8], exp[7:0]);
    end
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic w,
      input logic [3:0] be, input logic m16, input logic mx,
      input logic [31:0] b, input logic [31:0] m);
    @(negedge clk);
    addr_i = a; we_i = w; be_i = be; mode16_i = m16; mux_en_i = mx;
    cs_base_i = b; cs_mask_i = m;
    @(posedge clk);
    @(negedge clk);
    check(req, {cs_hit_o, oe_o, dm_o}, model(a, w, be, m16, mx, b, m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] GB_MASK = 32'hC000_0000;
  localparam logic [31:0] GB_BASE = 32'h4000_0000;

  initial begin
    void'($urandom(32'd1234));
    // R10: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10", {cs_hit_o, oe_o, dm_o}, {1'b0, 4'h0, 8'hFF});
    addr_i = GB_BASE; cs_base_i = GB_BASE; cs_mask_i = GB_MASK; we_i = 1'b1;
    rst = 1'b0;

    // R3 R4 R7: 32-bit halves, boundary on both sides
    access("R4", 32'h5FFF_FFFC, 1'b1, 4'b1010, 1'b0, 1'b1, GB_BASE, GB_MASK);
    access("R4", 32'h6000_0000, 1'b1, 4'b0110, 1'b0, 1'b1, GB_BASE, GB_MASK);
    access("R3", 32'h4000_0000, 1'b1, 4'b1111, 1'b0, 1'b1, GB_BASE, GB_MASK);
    access("R7", 32'h7FFF_FFFF, 1'b1, 4'b0001, 1'b0, 1'b1, GB_BASE, GB_MASK);
    // R5 R6: 16-bit quarters, be_i[3:2] set must be ignored
    access("R6", 32'h4000_0000, 1'b1, 4'b1101, 1'b1, 1'b1, GB_BASE, GB_MASK);
    access("R6", 32'h5000_0000, 1'b1, 4'b1110, 1'b1, 1'b1, GB_BASE, GB_MASK);
    access("R5", 32'h6FFF_FFFF, 1'b1, 4'b1111, 1'b1, 1'b1, GB_BASE, GB_MASK);
    access("R5", 32'h7000_0000, 1'b1, 4'b0011, 1'b1, 1'b1, GB_BASE, GB_MASK);
    // R8: reads keep mask set but still enable lanes
    access("R8", 32'h6000_0000, 1'b0, 4'b1111, 1'b0, 1'b1, GB_BASE, GB_MASK);
    access("R8", 32'h5000_0000, 1'b0, 4'b1111, 1'b1, 1'b1, GB_BASE, GB_MASK);
    // R1 R2: misses
    access("R2", 32'h8000_0000, 1'b1, 4'b1111, 1'b0, 1'b1, GB_BASE, GB_MASK);
    access("R1", 32'h3FFF_FFFF, 1'b1, 4'b1111, 1'b1, 1'b1, GB_BASE, GB_MASK);
    // R9: mux disabled, both modes, upper half
    access("R9", 32'h7000_0000, 1'b1, 4'b0101, 1'b0, 1'b0, GB_BASE, GB_MASK);
    access("R9", 32'h7000_0000, 1'b1, 4'b1110, 1'b1, 1'b0, GB_BASE, GB_MASK);
    // R7: tiny windows and zero mask
    access("R7", 32'h0000_0003, 1'b1, 4'b0011, 1'b1, 1'b1, 32'h0, 32'hFFFF_FFFE);
    access("R7", 32'h0000_0002, 1'b1, 4'b0011, 1'b1, 1'b1, 32'h0, 32'hFFFF_FFFC);
    access("R7", 32'h8000_0000, 1'b1, 4'b1001, 1'b0, 1'b1, 32'h0, 32'h0);
    access("R7", 32'hC000_0000, 1'b1, 4'b1001, 1'b1, 1'b1, 32'h0, 32'h0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int p; logic [31:0] m, b, a;
      p = 2 + int'($urandom_range(29));
      m = ~((32'h1 << p) - 32'h1);
      b = $urandom() & m;
      a = ($urandom_range(3) != 0) ? (b | ($urandom() & ~m)) : $urandom();
      access("R1", a, 1'($urandom()), 4'($urandom()), 1'($urandom()),
             ($urandom_range(4) != 0), b, m);
    end

    // R10: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10", {cs_hit_o, oe_o, dm_o}, {1'b0, 4'h0, 8'hFF});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule